// File: doc/BRIEF.md
# Fault collection state controller

This block gathers two groups of fault inputs, five software-recoverable and sixteen hardware-recoverable, into sticky status bits and drives a one-hot controller with four states: Normal, Alarm, Fault and Configuration. Each fault has an enable bit and a timeout-enable bit. A disabled fault is recorded but never moves the controller. An enabled fault with timeout-enable 0 escalates to Fault at once. An enabled fault with timeout-enable 1 first enters Alarm, where a programmable down-counter gives software time to clear the fault before the controller escalates to Fault.

Software reaches the block over a plain 32-bit register port with no handshake. A write takes effect at the next rising clock edge. Read data is combinational from the address. There is no back-pressure: every access completes in the cycle it is presented. Software fault 1 does not exist in this build. Its input, enable, timeout-enable and status bits are tied off.

Register map (byte offsets): 0x00 status (write 1 to clear), 0x04 fault enables, 0x08 alarm timeout value, 0x0C control (bit 0 requests Configuration), 0x1C timeout enables, 0x20 controller state (read-only). The status, enable and timeout-enable words share one layout: software fault i sits at bit 31-i, hardware fault j at bit j, and bits 26..16 always read zero.

Top module: `fcc_top`

## Requirements
- R1: After reset the state output and the state register read 0x0000_0001 (Normal), and the status, enable and timeout-enable registers read zero.
- R2: The state output has exactly one bit set after every clock: bit 0 Normal, bit 1 Alarm, bit 2 Fault, bit 3 Configuration.
- R3: A high fault input sets its status bit at the next edge (software fault i at bit 31-i, hardware fault j at bit j). The bit stays set until software writes 1 to it at offset 0x00. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: Software fault 1 (bit 30) is not implemented. Its status, enable and timeout-enable bits always read 0, and its input never changes the state.
- R5: An enabled, pending fault whose timeout-enable is 0 moves the controller from Normal or Alarm to Fault on the edge after its status bit is set.
- R6: An enabled, pending fault whose timeout-enable is 1 moves the controller from Normal to Alarm and loads the alarm counter from offset 0x08.
- R7: A pending fault whose enable bit is 0 causes no state change, whatever its timeout-enable bit holds.
- R8: When faults routed to Fault and faults routed to Alarm become pending in the same cycle, the controller goes to Fault.
- R9: With timeout value T, the controller stays in Alarm for exactly T+1 cycles while an alarm-routed fault stays pending, then enters Fault.
- R10: In Alarm, once no enabled status bit remains set, the controller returns to Normal at the next edge.
- R11: The controller leaves Fault for Normal only on the edge after every enabled status bit has been cleared.
- R12: Writing 1 to control bit 0 moves the controller from Normal to Configuration, where faults do not change the state. Writing 0 returns it to Normal. Writes to the state register at 0x20 have no effect.
- R13: The timeout-enable register at 0x1C is read/write and masked to implemented bits: writing all ones reads back 0xB800_FFFF. The enable register at 0x04 is masked the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_fault_i | input | 5 | Software-recoverable fault inputs, index 0..4 |
| hw_fault_i | input | 16 | Hardware-recoverable fault inputs, index 0..15 |
| reg_wr_i | input | 1 | Write strobe, applied at the next edge |
| reg_addr_i | input | 6 | Byte offset of the register accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| state_o | output | 4 | One-hot controller state |

## Verification
The bench builds the block with an 8-bit alarm counter instead of the 16-bit default. This puts both ends of the timeout range within a short run: a timeout of 0 gives a one-cycle Alarm, and mid-range values such as 5 and 20 let software clear the fault or a direct fault arrive while the counter is still running. The fault layout keeps its fixed widths, so every routing combination of enable and timeout-enable is exercised on real fault positions, including the tied-off software fault 1.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam int NUM_SW = 5;
  localparam int NUM_HW = 16;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADR_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_TMO    = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 6'h0C;
  localparam logic [ADDR_W-1:0] ADR_TOEN   = 6'h1C;
  localparam logic [ADDR_W-1:0] ADR_STATE  = 6'h20;

  typedef enum logic [3:0] {
    ST_NORMAL = 4'b0001,
    ST_ALARM  = 4'b0010,
    ST_FAULT  = 4'b0100,
    ST_CONFIG = 4'b1000
  } fcc_state_e;

  // Software fault i lands at bit WORD_W-1-i, hardware fault j at bit j.
  function automatic logic [WORD_W-1:0] pack_faults(
    input logic [NUM_SW-1:0] sw,
    input logic [NUM_HW-1:0] hw
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SW; i++) begin
      w[WORD_W-1-i] = sw[i];
    end
    w[NUM_HW-1:0] = hw;
    return w;
  endfunction

endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
  import fcc_pkg::*;
#(
  parameter int                TMR_W     = 16,
  parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] fault_word_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [3:0]        state_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] enable_o,
  output logic [WORD_W-1:0] toen_o,
  output logic [TMR_W-1:0]  tmo_o,
  output logic              cfg_req_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int PAD_W = WORD_W - TMR_W;

  logic              wr_status, wr_enable, wr_toen, wr_tmo, wr_ctrl;
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] clr_vec;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] enable_q, toen_q;
  logic [TMR_W-1:0]  tmo_q;
  logic              cfg_q;

  assign wr_status = wr_i && (addr_i == ADR_STATUS);
  assign wr_enable = wr_i && (addr_i == ADR_ENABLE);
  assign wr_toen   = wr_i && (addr_i == ADR_TOEN);
  assign wr_tmo    = wr_i && (addr_i == ADR_TMO);
  assign wr_ctrl   = wr_i && (addr_i == ADR_CTRL);

  assign set_vec = fault_word_i & IMPL_MASK;
  assign clr_vec = wr_status ? wdata_i : '0;

  // Sticky status: one flop per implemented fault position.
  for (genvar g = 0; g < WORD_W; g++) begin : g_status
    if (IMPL_MASK[g]) begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          status_q[g] <= 1'b0;
        end else if (set_vec[g]) begin
          status_q[g] <= 1'b1;
        end else if (clr_vec[g]) begin
          status_q[g] <= 1'b0;
        end
      end
    end else begin : g_tie
      assign status_q[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      toen_q   <= '0;
      tmo_q    <= '0;
      cfg_q    <= 1'b0;
    end else begin
      if (wr_enable) enable_q <= wdata_i & IMPL_MASK;
      if (wr_toen)   toen_q   <= wdata_i & IMPL_MASK;
      if (wr_tmo)    tmo_q    <= wdata_i[TMR_W-1:0];
      if (wr_ctrl)   cfg_q    <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_STATUS: rdata_o = status_q;
      ADR_ENABLE: rdata_o = enable_q;
      ADR_TMO:    rdata_o = {{PAD_W{1'b0}}, tmo_q};
      ADR_CTRL:   rdata_o = {{(WORD_W-1){1'b0}}, cfg_q};
      ADR_TOEN:   rdata_o = toen_q;
      ADR_STATE:  rdata_o = {{(WORD_W-4){1'b0}}, state_i};
      default:    rdata_o = '0;
    endcase
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign toen_o    = toen_q;
  assign tmo_o     = tmo_q;
  assign cfg_req_o = cfg_q;

endmodule

// File: rtl/fcc_route.sv
module fcc_route
  import fcc_pkg::*;
#(
  parameter logic [WORD_W-1:0] IMPL_MASK = '1
) (
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] enable_i,
  input  logic [WORD_W-1:0] toen_i,
  output logic              pend_direct_o,
  output logic              pend_alarm_o
);

  logic [WORD_W-1:0] hit_direct;
  logic [WORD_W-1:0] hit_alarm;

  // Per-fault routing: the enable gates the fault, timeout-enable picks the path.
  for (genvar g = 0; g < WORD_W; g++) begin : g_route
    if (IMPL_MASK[g]) begin : g_live
      logic armed;
      assign armed         = status_i[g] & enable_i[g];
      assign hit_direct[g] = armed & ~toen_i[g];
      assign hit_alarm[g]  = armed &  toen_i[g];
    end else begin : g_dead
      assign hit_direct[g] = 1'b0;
      assign hit_alarm[g]  = 1'b0;
    end
  end

  assign pend_direct_o = |hit_direct;
  assign pend_alarm_o  = |hit_alarm;

endmodule

// File: rtl/fcc_fsm.sv
module fcc_fsm
  import fcc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_direct_i,
  input  logic             pend_alarm_i,
  input  logic             cfg_req_i,
  input  logic [TMR_W-1:0] tmo_i,
  output logic [3:0]       state_o,
  output logic [TMR_W-1:0] cnt_o
);

  fcc_state_e       state_q, state_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (pend_direct_i) begin
          state_d = ST_FAULT;
        end else if (pend_alarm_i) begin
          state_d = ST_ALARM;
          cnt_d   = tmo_i;
        end else if (cfg_req_i) begin
          state_d = ST_CONFIG;
        end
      end
      ST_ALARM: begin
        if (pend_direct_i) begin
          state_d = ST_FAULT;
        end else if (!pend_alarm_i) begin
          state_d = ST_NORMAL;
        end else if (cnt_zero) begin
          state_d = ST_FAULT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_FAULT: begin
        if (!pend_direct_i && !pend_alarm_i) state_d = ST_NORMAL;
      end
      ST_CONFIG: begin
        if (!cfg_req_i) state_d = ST_NORMAL;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/fcc_top.sv
module fcc_top
  import fcc_pkg::*;
#(
  parameter int                TMR_W   = 16,
  parameter logic [NUM_SW-1:0] SW_IMPL = 5'b11101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SW-1:0] sw_fault_i,
  input  logic [NUM_HW-1:0] hw_fault_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [3:0]        state_o
);

  localparam logic [WORD_W-1:0] IMPL_MASK = pack_faults(SW_IMPL, '1);

  logic [WORD_W-1:0] fault_word;
  logic [WORD_W-1:0] status, enable, toen;
  logic [TMR_W-1:0]  tmo, alarm_cnt;
  logic              cfg_req, pend_direct, pend_alarm;

  assign fault_word = pack_faults(sw_fault_i, hw_fault_i);

  fcc_regs #(.TMR_W(TMR_W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_word_i (fault_word),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .state_i      (state_o),
    .status_o     (status),
    .enable_o     (enable),
    .toen_o       (toen),
    .tmo_o        (tmo),
    .cfg_req_o    (cfg_req),
    .rdata_o      (reg_rdata_o)
  );

  fcc_route #(.IMPL_MASK(IMPL_MASK)) u_route (
    .status_i      (status),
    .enable_i      (enable),
    .toen_i        (toen),
    .pend_direct_o (pend_direct),
    .pend_alarm_o  (pend_alarm)
  );

  fcc_fsm #(.TMR_W(TMR_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pend_direct_i (pend_direct),
    .pend_alarm_i  (pend_alarm),
    .cfg_req_i     (cfg_req),
    .tmo_i         (tmo),
    .state_o       (state_o),
    .cnt_o         (alarm_cnt)
  );

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        state_o,
  input logic              pend_direct,
  input logic              pend_alarm,
  input logic              cfg_req,
  input logic [TMR_W-1:0]  alarm_cnt,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [WORD_W-1:0] reg_rdata_o
);

  localparam logic [TMR_W-1:0] CNT_ONE = 1;

  a_r2_state_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  // R5 and R8: a direct-routed fault wins from Normal or Alarm.
  a_r5_direct_to_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == ST_NORMAL || state_o == ST_ALARM) && pend_direct)
    |=> state_o == ST_FAULT);

  a_r6_alarm_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_NORMAL && !pend_direct && pend_alarm) |=> state_o == ST_ALARM);

  a_r9_alarm_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ALARM && pend_alarm && !pend_direct && alarm_cnt != '0)
    |=> (state_o == ST_ALARM && alarm_cnt + CNT_ONE == $past(alarm_cnt)));

  a_r10_alarm_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ALARM && !pend_direct && !pend_alarm) |=> state_o == ST_NORMAL);

  a_r11_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FAULT && (pend_direct || pend_alarm)) |=> state_o == ST_FAULT);

  a_r12_config_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CONFIG && cfg_req) |=> state_o == ST_CONFIG);

  a_r4_sw1_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADR_STATUS || reg_addr_i == ADR_ENABLE || reg_addr_i == ADR_TOEN)
    |-> reg_rdata_o[30] == 1'b0);

endmodule

bind fcc_top fcc_checker #(.TMR_W(TMR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_o     (state_o),
  .pend_direct (pend_direct),
  .pend_alarm  (pend_alarm),
  .cfg_req     (cfg_req),
  .alarm_cnt   (alarm_cnt),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/test_fcc_top.sv
module test_fcc_top;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam logic [31:0] MASK = 32'hB800_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sw = '0;
  logic [15:0] hw = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  state;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcc_top #(.TMR_W(TW)) i_fcc_top (
    .clk_i(clk), .rst_ni(rst_n), .sw_fault_i(sw), .hw_fault_i(hw),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .state_o(state)
  );

  // Behavioural reference: state as an index 0..3, registers as plain words.
  int          m_state = 0;
  int          m_cnt = 0;
  logic [31:0] m_status = '0, m_en = '0, m_ter = '0;
  int          m_tmo = 0;
  bit          m_cfg = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_status = '0; m_en = '0; m_ter = '0;
      m_tmo = 0; m_cfg = 0;
    end else begin
      bit pd, pa;
      logic [31:0] setw;
      pd = 0; pa = 0;
      for (int b = 0; b < 32; b++)
        if (m_status[b] && m_en[b]) begin
          if (m_ter[b]) pa = 1; else pd = 1;
        end
      setw = '0;
      for (int i = 0; i < 5; i++) if (i != 1 && sw[i]) setw[31-i] = 1'b1;
      setw[15:0] = hw;
      case (m_state)
        0: if (pd) m_state = 2;
           else if (pa) begin m_state = 1; m_cnt = m_tmo; end
           else if (m_cfg) m_state = 3;
        1: if (pd) m_state = 2;
           else if (!pa) m_state = 0;
           else if (m_cnt == 0) m_state = 2;
           else m_cnt = m_cnt - 1;
        2: if (!pd && !pa) m_state = 0;
        default: if (!m_cfg) m_state = 0;
      endcase
      if (wr && addr == 6'h00) m_status = (m_status & ~wdata) | setw;
      else m_status = m_status | setw;
      if (wr && addr == 6'h04) m_en = wdata & MASK;
      if (wr && addr == 6'h1C) m_ter = wdata & MASK;
      if (wr && addr == 6'h08) m_tmo = int'(wdata[TW-1:0]);
      if (wr && addr == 6'h0C) m_cfg = wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every clock: state matches the model and is one-hot (R2).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model state", {28'b0, state}, 32'(1 << m_state));
      chk("R2 onehot", 32'($countones(state)), 32'd1);
    end
  end

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rreg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
    addr = '0;
  endtask

  task automatic pulse(input logic [4:0] s, input logic [15:0] h);
    @(negedge clk);
    sw = s; hw = h;
    @(negedge clk);
    sw = '0; hw = '0;
  endtask

  task automatic clear_all();
    wreg(6'h00, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic alarm_len(output int n);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (state == 4'b0010) n++;
      else if (state == 4'b0100) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 state out", {28'b0, state}, 32'h1);
    rreg("R1 state reg", 6'h20, 32'h1);
    rreg("R1 status", 6'h00, 32'h0);
    rreg("R1 enable", 6'h04, 32'h0);
    rreg("R1 toen", 6'h1C, 32'h0);

    // R13: masked read/write of timeout enables and enables
    wreg(6'h1C, 32'hFFFF_FFFF);
    rreg("R13 toen mask", 6'h1C, 32'hB800_FFFF);
    wreg(6'h1C, 32'h0);
    rreg("R13 toen clear", 6'h1C, 32'h0);

    // R7: disabled fault latches but does not move state
    wreg(6'h1C, 32'h0000_0008);
    pulse(5'b0, 16'h0008);
    repeat (2) @(negedge clk);
    chk("R7 disabled no move", {28'b0, state}, 32'h1);
    rreg("R3 hw3 latched", 6'h00, 32'h0000_0008);
    wreg(6'h00, 32'h0000_0008);
    rreg("R3 w1c clears", 6'h00, 32'h0);

    // R3: set wins over a same-cycle clear
    @(negedge clk);
    hw = 16'h0020; wr = 1'b1; addr = 6'h00; wdata = 32'h0000_0020;
    @(negedge clk);
    hw = '0; wr = 1'b0; addr = '0; wdata = '0;
    rreg("R3 set beats clear", 6'h00, 32'h0000_0020);
    wreg(6'h00, 32'h0000_0020);
    rreg("R3 cleared", 6'h00, 32'h0);

    // R13/R4: enable mask; software fault 1 has no effect
    wreg(6'h1C, 32'h0);
    wreg(6'h04, 32'hFFFF_FFFF);
    rreg("R13 enable mask", 6'h04, 32'hB800_FFFF);
    pulse(5'b00010, 16'h0);
    repeat (2) @(negedge clk);
    chk("R4 sw1 no move", {28'b0, state}, 32'h1);
    rreg("R4 sw1 status zero", 6'h00, 32'h0);

    // R5: direct escalation from Normal; R11 exit
    pulse(5'b00001, 16'h0);
    @(negedge clk);
    chk("R5 sw0 to fault", {28'b0, state}, 32'h4);
    rreg("R3 sw0 at bit31", 6'h00, 32'h8000_0000);
    wreg(6'h00, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 fault to normal", {28'b0, state}, 32'h1);

    // R11: partial clear keeps Fault
    pulse(5'b0, 16'h0050);
    @(negedge clk);
    chk("R11 two faults", {28'b0, state}, 32'h4);
    wreg(6'h00, 32'h0000_0010);
    repeat (2) @(negedge clk);
    chk("R11 partial clear holds", {28'b0, state}, 32'h4);
    wreg(6'h00, 32'h0000_0040);
    @(negedge clk);
    chk("R11 full clear exits", {28'b0, state}, 32'h1);

    // R6/R9: alarm of length T+1, T=5
    wreg(6'h1C, 32'h0000_0001);
    wreg(6'h08, 32'd5);
    pulse(5'b0, 16'h0001);
    alarm_len(n);
    chk("R9 alarm T=5 length", 32'(n), 32'd6);
    chk("R6 alarm then fault", {28'b0, state}, 32'h4);
    clear_all();

    // R9: boundary T=0
    wreg(6'h08, 32'd0);
    pulse(5'b0, 16'h0001);
    alarm_len(n);
    chk("R9 alarm T=0 length", 32'(n), 32'd1);
    clear_all();

    // R10: clearing during Alarm returns to Normal
    wreg(6'h08, 32'd20);
    pulse(5'b0, 16'h0001);
    @(negedge clk);
    chk("R6 enter alarm", {28'b0, state}, 32'h2);
    repeat (3) @(negedge clk);
    wreg(6'h00, 32'h0000_0001);
    @(negedge clk);
    chk("R10 alarm to normal", {28'b0, state}, 32'h1);

    // R5: direct fault while in Alarm
    pulse(5'b0, 16'h0001);
    @(negedge clk);
    chk("R6 alarm again", {28'b0, state}, 32'h2);
    pulse(5'b0, 16'h0002);
    @(negedge clk);
    chk("R5 alarm to fault", {28'b0, state}, 32'h4);
    clear_all();

    // R8: both kinds in one cycle
    pulse(5'b0, 16'h0003);
    @(negedge clk);
    chk("R8 fault beats alarm", {28'b0, state}, 32'h4);
    clear_all();
    chk("R8 recovered", {28'b0, state}, 32'h1);

    // R12: configuration state
    wreg(6'h0C, 32'h1);
    @(negedge clk);
    chk("R12 enter config", {28'b0, state}, 32'h8);
    pulse(5'b0, 16'h0004);
    repeat (2) @(negedge clk);
    chk("R12 faults ignored", {28'b0, state}, 32'h8);
    wreg(6'h20, 32'h0);
    rreg("R12 state write ignored", 6'h20, 32'h8);
    wreg(6'h00, 32'hFFFF_FFFF);
    wreg(6'h0C, 32'h0);
    @(negedge clk);
    chk("R12 leave config", {28'b0, state}, 32'h1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule